// File: doc/BRIEF.md
# Power-Loss DRAM Save Sequencer

This block is the on-module controller that takes the DRAM away from the host when power is lost, or when a save is commanded, and copies the DRAM contents into flash. A save begins in one of two ways: a power-fail trigger, which always saves the whole array, or a save command, which saves either the whole array or a window given by a start word and a word count. After a trigger, the block waits until the host reports that the DRAM has been placed in self-refresh. Only then does it take over the DRAM, in a fixed order, one step per clock: it switches the data and control muxes to the local side, enables the backup energy source, selects the slower local clock, and brings the DRAM out of self-refresh.

The copy runs over two simple request/acknowledge ports. A DRAM read port returns one word per request. A flash write port accepts one word per request and may flag a failure with its acknowledge. DRAM reads are issued at most once per `SLOW_DIV` cycles, which models the lower local DRAM rate. When the copy ends, backup power is removed and the status outputs are updated. The status outputs are a busy flag, a save-done flag, a valid-image flag, and two error flags: one for a self-refresh timeout and one for a flash failure.

Top module: `save_seq_top`

## Requirements
- R1: Out of reset and while idle, every control and status output is 0. A high `srDone` without a trigger leaves the muxes on the host side.
- R2: After a trigger, the block does not take the DRAM (`muxSelLocal`=0, `saveBusy`=0) until `srDone` is sampled high.
- R3: In the cycle after `srDone` is sampled, `muxSelLocal` rises while `backupPwrEn` is still 0. `backupPwrEn` rises one clock later, then `clkSlowSel`, then `localCke`, each one clock after the previous one.
- R4: If `srDone` is not sampled high within `srTimeout` cycles of waiting, `errTimeout` is set on the clock after the last waiting cycle and the DRAM is never taken. `srDone` sampled in the last waiting cycle still starts the save.
- R5: A `powerFail` trigger copies all 2^AW words to the same flash addresses and ignores `partialMode`.
- R6: A `saveCmd` trigger with `partialMode`=1 copies `saveLen` words starting at `startAddr`, with addresses wrapping modulo 2^AW. Flash words outside the window are not written.
- R7: A partial save with `saveLen`=0 completes with `saveDone`=1 and no flash write.
- R8: `backupPwrEn` is 0 once the copy has finished or failed.
- R9: A successful save sets `saveDone` and `dataValid`. Both hold until the next trigger clears them.
- R10: A flash acknowledge with `flashErr`=1 stops the copy. No later word is written, `errFlash` is set, and `dataValid` and `saveDone` stay 0.
- R11: `saveBusy` is 1 from the mux switch through the end of the copy, and is 0 once the save is done or has failed.
- R12: Flash and DRAM requests are issued only while the block owns the DRAM (`muxSelLocal`=1 and `localCke`=1). A DRAM request holds its address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerFail | input | 1 | Power-loss trigger (full save) |
| saveCmd | input | 1 | Commanded save trigger |
| partialMode | input | 1 | With saveCmd: 1 = window save, 0 = full save |
| startAddr | input | AW | First word of a window save |
| saveLen | input | AW+1 | Word count of a window save (clamped to 2^AW) |
| srTimeout | input | TW | Maximum cycles to wait for srDone |
| srDone | input | 1 | Host reports DRAM is in self-refresh |
| muxSelLocal | output | 1 | 1 = DRAM data/control muxes switched to the block |
| backupPwrEn | output | 1 | Enable for the backup energy source |
| clkSlowSel | output | 1 | Select the slower local DRAM clock |
| localCke | output | 1 | Local clock enable: DRAM out of self-refresh |
| dramReq | output | 1 | DRAM read request |
| dramAddr | output | AW | DRAM read word address |
| dramAck | input | 1 | DRAM read acknowledge, data valid |
| dramRdata | input | DW | DRAM read data |
| flashReq | output | 1 | Flash write request |
| flashAddr | output | AW | Flash write word address |
| flashWdata | output | DW | Flash write data |
| flashAck | input | 1 | Flash write acknowledge |
| flashErr | input | 1 | Flash write failed (valid with flashAck) |
| saveBusy | output | 1 | Save in progress |
| saveDone | output | 1 | Last save completed |
| dataValid | output | 1 | Flash holds a good image |
| errTimeout | output | 1 | Self-refresh handshake timed out |
| errFlash | output | 1 | Flash write failure |

## Verification
The assertions check the handover order on every cycle: the muxes switch only after `srDone` is sampled, power comes on only after the muxes, and the slow clock comes on only after power. They also check that backup power is off when done is raised, that a flash error never coexists with a valid image, and that requests appear only during the copy and hold their address until acknowledged. The bench scenarios cover what no single-cycle property can show. These are the exact flash image after full, windowed, wrapping and empty saves, the timeout cycle count at its boundary, the number of words written before a flash failure, and how status is held or cleared across consecutive saves.

// File: rtl/save_seq_pkg.sv
package save_seq_pkg;

  typedef enum logic [3:0] {
    IDLE,
    WAIT_SR,
    ISOLATE,
    PWR_SWITCH,
    CLK_SWITCH,
    EXIT_SR,
    COPY,
    DONE,
    ERROR
  } seqState_t;

  typedef struct packed {
    logic latchCfg;
    logic fullMode;
    logic copyEn;
  } seqStrobe_t;

endpackage

// File: rtl/save_seq_ctrl.sv
module save_seq_ctrl
  import save_seq_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          powerFail,
  input  logic          saveCmd,
  input  logic          partialMode,
  input  logic [TW-1:0] srTimeout,
  input  logic          srDone,
  input  logic          copyDone,
  input  logic          copyFail,
  output seqStrobe_t    strobe,
  output logic          muxSelLocal,
  output logic          backupPwrEn,
  output logic          clkSlowSel,
  output logic          localCke,
  output logic          saveBusy,
  output logic          saveDone,
  output logic          dataValid,
  output logic          errTimeout,
  output logic          errFlash
);

  seqState_t     state;
  logic [TW-1:0] waitCnt;
  logic [TW:0]   waitNext;
  logic          trigger;

  assign trigger  = powerFail | saveCmd;
  assign waitNext = {1'b0, waitCnt} + {{TW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= IDLE;
      waitCnt    <= '0;
      saveDone   <= 1'b0;
      dataValid  <= 1'b0;
      errTimeout <= 1'b0;
      errFlash   <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (trigger) begin
          state      <= WAIT_SR;
          waitCnt    <= '0;
          saveDone   <= 1'b0;
          dataValid  <= 1'b0;
          errTimeout <= 1'b0;
          errFlash   <= 1'b0;
        end
        WAIT_SR: begin
          if (srDone) begin
            state <= ISOLATE;
          end else if (waitNext >= {1'b0, srTimeout}) begin
            state      <= ERROR;
            errTimeout <= 1'b1;
          end else begin
            waitCnt <= waitNext[TW-1:0];
          end
        end
        ISOLATE:    state <= PWR_SWITCH;
        PWR_SWITCH: state <= CLK_SWITCH;
        CLK_SWITCH: state <= EXIT_SR;
        EXIT_SR:    state <= COPY;
        COPY: begin
          if (copyFail) begin
            state    <= ERROR;
            errFlash <= 1'b1;
          end else if (copyDone) begin
            state     <= DONE;
            saveDone  <= 1'b1;
            dataValid <= 1'b1;
          end
        end
        DONE:    state <= IDLE;
        ERROR:   state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  // Ownership window: from the mux switch to the end of the copy
  assign muxSelLocal = (state >= ISOLATE)    && (state <= COPY);
  assign saveBusy    = (state >= ISOLATE)    && (state <= COPY);
  assign backupPwrEn = (state >= PWR_SWITCH) && (state <= COPY);
  assign clkSlowSel  = (state >= CLK_SWITCH) && (state <= COPY);
  assign localCke    = (state == EXIT_SR)    || (state == COPY);

  assign strobe.latchCfg = (state == IDLE) && trigger;
  assign strobe.fullMode = powerFail | ~partialMode;
  assign strobe.copyEn   = (state == COPY);

  AST_ISO_AFTER_SR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muxSelLocal) |-> $past(srDone)); // R2
  AST_PWR_AFTER_ISO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(backupPwrEn) |-> $past(muxSelLocal) && muxSelLocal); // R3
  AST_CLK_AFTER_PWR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSlowSel) |-> $past(backupPwrEn) && backupPwrEn); // R3
  AST_PWR_OFF_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(saveDone) |-> !backupPwrEn && !saveBusy); // R8
  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    errFlash |-> !dataValid && !saveDone); // R10
  AST_TIMEOUT_NO_OWN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> !muxSelLocal && !$past(muxSelLocal)); // R4

endmodule

// File: rtl/save_seq_dp.sv
module save_seq_dp
  import save_seq_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 16,
  parameter int SLOW_DIV = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [AW-1:0] startAddr,
  input  logic [AW:0]   saveLen,
  output logic          dramReq,
  output logic [AW-1:0] dramAddr,
  input  logic          dramAck,
  input  logic [DW-1:0] dramRdata,
  output logic          flashReq,
  output logic [AW-1:0] flashAddr,
  output logic [DW-1:0] flashWdata,
  input  logic          flashAck,
  input  logic          flashErr,
  output logic          copyDone,
  output logic          copyFail
);

  localparam int LW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int DVW   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [AW-1:0]  addr;
  logic [LW-1:0]  remaining;
  logic [LW-1:0]  winLen;
  logic [DW-1:0]  dataReg;
  logic [DVW-1:0] divCnt;
  logic           rdActive, wrActive, failFlag, slowTick, launch;

  assign winLen   = (saveLen > LW'(DEPTH)) ? LW'(DEPTH) : saveLen;
  assign slowTick = (divCnt == '0);
  assign launch   = strobe.copyEn && !rdActive && !wrActive && !failFlag
                    && (remaining != '0) && slowTick;

  // Local rate divider: one DRAM access slot every SLOW_DIV cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            divCnt <= '0;
    else if (!strobe.copyEn)              divCnt <= '0;
    else if (divCnt == DVW'(SLOW_DIV - 1)) divCnt <= '0;
    else                                  divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr      <= '0;
      remaining <= '0;
      dataReg   <= '0;
      rdActive  <= 1'b0;
      wrActive  <= 1'b0;
      failFlag  <= 1'b0;
    end else if (strobe.latchCfg) begin
      addr      <= strobe.fullMode ? '0 : startAddr;
      remaining <= strobe.fullMode ? LW'(DEPTH) : winLen;
      rdActive  <= 1'b0;
      wrActive  <= 1'b0;
      failFlag  <= 1'b0;
    end else begin
      if (launch) rdActive <= 1'b1;
      if (rdActive && dramAck) begin
        rdActive <= 1'b0;
        wrActive <= 1'b1;
        dataReg  <= dramRdata;
      end
      if (wrActive && flashAck) begin
        wrActive <= 1'b0;
        if (flashErr) begin
          failFlag <= 1'b1;
        end else begin
          addr      <= addr + 1'b1;
          remaining <= remaining - 1'b1;
        end
      end
    end
  end

  assign dramReq    = rdActive;
  assign dramAddr   = addr;
  assign flashReq   = wrActive;
  assign flashAddr  = addr;
  assign flashWdata = dataReg;
  assign copyFail   = failFlag;
  assign copyDone   = strobe.copyEn && (remaining == '0) && !rdActive && !wrActive;

  AST_FLASH_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq || dramReq) |-> strobe.copyEn); // R12
  AST_DRAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dramReq && !dramAck) |=> dramReq && $stable(dramAddr)); // R12
  AST_NO_WRITE_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strobe.latchCfg) |=> !flashReq); // R10

endmodule

// File: rtl/save_seq_top.sv
module save_seq_top
  import save_seq_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 16,
  parameter int TW       = 8,
  parameter int SLOW_DIV = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          powerFail,
  input  logic          saveCmd,
  input  logic          partialMode,
  input  logic [AW-1:0] startAddr,
  input  logic [AW:0]   saveLen,
  input  logic [TW-1:0] srTimeout,
  input  logic          srDone,
  output logic          muxSelLocal,
  output logic          backupPwrEn,
  output logic          clkSlowSel,
  output logic          localCke,
  output logic          dramReq,
  output logic [AW-1:0] dramAddr,
  input  logic          dramAck,
  input  logic [DW-1:0] dramRdata,
  output logic          flashReq,
  output logic [AW-1:0] flashAddr,
  output logic [DW-1:0] flashWdata,
  input  logic          flashAck,
  input  logic          flashErr,
  output logic          saveBusy,
  output logic          saveDone,
  output logic          dataValid,
  output logic          errTimeout,
  output logic          errFlash
);

  seqStrobe_t strobe;
  logic       copyDone, copyFail;

  save_seq_ctrl #(.TW(TW)) ctrl_i (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .saveCmd(saveCmd),
    .partialMode(partialMode), .srTimeout(srTimeout), .srDone(srDone),
    .copyDone(copyDone), .copyFail(copyFail), .strobe(strobe),
    .muxSelLocal(muxSelLocal), .backupPwrEn(backupPwrEn), .clkSlowSel(clkSlowSel),
    .localCke(localCke), .saveBusy(saveBusy), .saveDone(saveDone),
    .dataValid(dataValid), .errTimeout(errTimeout), .errFlash(errFlash)
  );

  save_seq_dp #(.AW(AW), .DW(DW), .SLOW_DIV(SLOW_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr), .saveLen(saveLen),
    .dramReq(dramReq), .dramAddr(dramAddr), .dramAck(dramAck), .dramRdata(dramRdata),
    .flashReq(flashReq), .flashAddr(flashAddr), .flashWdata(flashWdata),
    .flashAck(flashAck), .flashErr(flashErr), .copyDone(copyDone), .copyFail(copyFail)
  );

endmodule

// File: tb/save_seq_top_tb_top.sv
module save_seq_top_tb_top;
  localparam int AW = 5, DW = 16, TW = 8, DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic powerFail = 0, saveCmd = 0, partialMode = 0, srDone = 0;
  logic [AW-1:0] startAddr = '0;
  logic [AW:0]   saveLen = '0;
  logic [TW-1:0] srTimeout = 8'd20;
  logic dramReq, flashReq, dramAck = 0, flashAck = 0, flashErr = 0;
  logic [AW-1:0] dramAddr, flashAddr;
  logic [DW-1:0] dramRdata = '0, flashWdata;
  logic muxSelLocal, backupPwrEn, clkSlowSel, localCke, saveBusy;
  logic saveDone, dataValid, errTimeout, errFlash;

  logic [DW-1:0] dmem [DEPTH];
  logic [DW-1:0] fmem [DEPTH];
  int nChecks = 0, nFails = 0, flashWrites = 0, ownViol = 0, fwait = 0;
  logic injectErr = 0;
  logic [AW-1:0] errAddr = '0;

  save_seq_top #(.AW(AW), .DW(DW), .TW(TW), .SLOW_DIV(2)) dut_i (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .saveCmd(saveCmd),
    .partialMode(partialMode), .startAddr(startAddr), .saveLen(saveLen),
    .srTimeout(srTimeout), .srDone(srDone), .muxSelLocal(muxSelLocal),
    .backupPwrEn(backupPwrEn), .clkSlowSel(clkSlowSel), .localCke(localCke),
    .dramReq(dramReq), .dramAddr(dramAddr), .dramAck(dramAck), .dramRdata(dramRdata),
    .flashReq(flashReq), .flashAddr(flashAddr), .flashWdata(flashWdata),
    .flashAck(flashAck), .flashErr(flashErr), .saveBusy(saveBusy), .saveDone(saveDone),
    .dataValid(dataValid), .errTimeout(errTimeout), .errFlash(errFlash)
  );

  // Memory models, driven away from the active edge
  always @(negedge clk) begin
    if (dramReq && !(localCke && muxSelLocal)) ownViol++;
    if (flashReq && !(localCke && muxSelLocal)) ownViol++;
    if (dramReq && !dramAck) begin
      dramAck = 1'b1;
      dramRdata = dmem[dramAddr];
    end else begin
      dramAck = 1'b0;
    end
    if (flashReq && !flashAck) begin
      if (fwait == 0) begin
        flashAck = 1'b1;
        if (injectErr && flashAddr == errAddr) flashErr = 1'b1;
        else begin
          flashErr = 1'b0;
          fmem[flashAddr] = flashWdata;
          flashWrites++;
        end
        fwait = $urandom_range(0, 2);
      end else fwait--;
    end else begin
      flashAck = 1'b0;
      flashErr = 1'b0;
    end
  end

  function automatic logic [DW-1:0] sentinel(input int a);
    return 16'hA500 | DW'(a);
  endfunction

  function automatic bit inWindow(input bit full, input int st, input int len, input int a);
    return full || (((a - st + DEPTH) % DEPTH) < len);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep();
    for (int a = 0; a < DEPTH; a++) begin
      dmem[a] = DW'($urandom);
      if (dmem[a] == sentinel(a)) dmem[a] = ~dmem[a];
      fmem[a] = sentinel(a);
    end
    flashWrites = 0;
  endtask

  task automatic fire(input bit pf, input bit part, input int st, input int len);
    startAddr = AW'(st);
    saveLen = (AW+1)'(len);
    partialMode = part;
    if (pf) powerFail = 1'b1; else saveCmd = 1'b1;
    step(1);
    powerFail = 1'b0;
    saveCmd = 1'b0;
  endtask

  task automatic waitEnd();
    int guard = 0;
    while (!(saveDone || errFlash || errTimeout) && guard < 4000) begin
      step(1);
      guard++;
    end
    step(2);
    srDone = 1'b0;
  endtask

  task automatic verifyImage(input string tag, input bit full, input int st, input int len);
    int mism = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] exp;
      exp = inWindow(full, st, len, a) ? dmem[a] : sentinel(a);
      if (fmem[a] !== exp) mism++;
    end
    chk(tag, mism, 0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20140805));
    prep();
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 reset outputs", int'({muxSelLocal, backupPwrEn, clkSlowSel, localCke, saveBusy,
        saveDone, dataValid, errTimeout, errFlash}), 0);
    srDone = 1'b1;
    step(4);
    chk("R1 srDone ignored when idle", int'({muxSelLocal, saveBusy, backupPwrEn}), 0);
    srDone = 1'b0;

    // Directed handover order plus full save from power fail
    prep();
    fire(1'b1, 1'b1, 3, 4);
    step(3);
    chk("R2 no takeover before srDone", int'({muxSelLocal, saveBusy}), 0);
    srDone = 1'b1;
    step(1);
    chk("R3 mux first, power off", int'({muxSelLocal, backupPwrEn}), 2);
    chk("R11 busy at mux switch", int'(saveBusy), 1);
    step(1);
    chk("R3 power then, clock not yet", int'({backupPwrEn, clkSlowSel}), 2);
    step(1);
    chk("R3 slow clock then, cke not yet", int'({clkSlowSel, localCke}), 2);
    step(1);
    chk("R3 cke last", int'(localCke), 1);
    waitEnd();
    chk("R5 full write count", flashWrites, DEPTH);
    verifyImage("R5 full image", 1'b1, 0, 0);
    chk("R9 done and valid", int'({saveDone, dataValid}), 3);
    chk("R8 power off after copy", int'(backupPwrEn), 0);
    chk("R11 busy cleared", int'({saveBusy, muxSelLocal}), 0);
    step(5);
    chk("R9 status held", int'({saveDone, dataValid}), 3);

    // Window save that wraps past the top address
    prep();
    fire(1'b0, 1'b1, DEPTH - 3, 7);
    srDone = 1'b1;
    waitEnd();
    chk("R6 wrap write count", flashWrites, 7);
    verifyImage("R6 wrap image", 1'b0, DEPTH - 3, 7);

    // Empty window
    prep();
    fire(1'b0, 1'b1, 9, 0);
    srDone = 1'b1;
    waitEnd();
    chk("R7 empty writes", flashWrites, 0);
    chk("R7 empty done", int'({saveDone, dataValid}), 3);

    // Timeout
    srTimeout = 8'd5;
    prep();
    fire(1'b0, 1'b0, 0, 0);
    chk("R9 status cleared by trigger", int'({saveDone, dataValid}), 0);
    step(4);
    chk("R4 not yet timed out", int'(errTimeout), 0);
    step(1);
    chk("R4 timeout flagged", int'(errTimeout), 1);
    chk("R4 DRAM never taken", int'({muxSelLocal, saveBusy, backupPwrEn}), 0);
    step(3);
    chk("R4 no writes on timeout", flashWrites, 0);

    // srDone in the last waiting cycle still succeeds
    prep();
    fire(1'b0, 1'b0, 0, 0);
    step(4);
    srDone = 1'b1;
    waitEnd();
    chk("R4 boundary no timeout", int'(errTimeout), 0);
    chk("R4 boundary done", int'(saveDone), 1);
    srTimeout = 8'd20;

    // Flash failure on the third word of a window
    prep();
    injectErr = 1'b1;
    errAddr = AW'(12);
    fire(1'b0, 1'b1, 10, 6);
    srDone = 1'b1;
    waitEnd();
    injectErr = 1'b0;
    chk("R10 flash error flag", int'(errFlash), 1);
    chk("R10 no valid, no done", int'({dataValid, saveDone}), 0);
    chk("R10 writes before failure", flashWrites, 2);
    chk("R8 power off after failure", int'({backupPwrEn, saveBusy}), 0);

    // Constrained random saves
    for (int it = 0; it < 10; it++) begin
      int st, len, dly;
      bit full;
      st = $urandom_range(0, DEPTH - 1);
      len = $urandom_range(0, DEPTH);
      dly = $urandom_range(0, 4);
      full = ($urandom_range(0, 3) == 0);
      prep();
      fire(1'b0, !full, st, len);
      step(dly);
      srDone = 1'b1;
      waitEnd();
      chk("R6 random write count", flashWrites, full ? DEPTH : len);
      verifyImage("R6 random image", full, st, len);
      chk("R9 random done", int'({saveDone, dataValid, errFlash}), 6);
    end
    chk("R12 accesses only while owned", ownViol, 0);
    finishRun();
  end

endmodule